// File: doc/BRIEF.md
# Load-Linked / Store-Conditional Reservation Monitor

This block sits in front of one single-ported word memory that several requesters share. It lets them build atomic read-modify-write sequences such as spin locks and counters. Each requester issues one of four operations: a plain load, a plain store, a linked load, or a conditional store. A linked load returns the word and records a reservation for that requester. A later conditional store from the same requester writes only if that reservation is still intact. It returns 1 on success and 0 on failure. Any write to a reserved word breaks the reservation, and that includes the release store of a lock.

Only one operation reaches the memory per cycle. When several requesters are pending, the one with the lowest index is granted. The others keep their request asserted until they are granted. Every granted operation gets exactly one response on the next cycle. When two requesters race with conditional stores to the same word, they are served in turn. The first write clears the second requester's reservation, so the second store fails.

Top module: `llsc_monitor`

## Requirements
- R1: A plain load (op code 2'b00) returns the addressed word on `rsp_data` and changes no reservation and no memory word.
- R2: A linked load (op code 2'b10) returns the addressed word and sets that requester's reservation to the address. A new linked load replaces the previous reservation, so a conditional store to the old address then fails.
- R3: A conditional store (op code 2'b11) from a requester that holds a reservation on the same address writes the word and returns the value 1 (bit 0 set, all other bits zero).
- R4: A conditional store without a matching reservation returns 0 and leaves memory unchanged. This covers both no reservation at all and a reservation on another address.
- R5: Every conditional store clears the issuing requester's reservation, whether it succeeds or fails, so a second one in a row fails.
- R6: A plain store (op code 2'b01) writes the word and returns 0. It clears every reservation on that word, whichever requester holds it. A store to a different word leaves the reservation intact.
- R7: At most one requester is granted per cycle. The granted one is the lowest-index requester that has `req_valid` set. A requester that is not granted keeps waiting.
- R8: When two requesters issue conditional stores to the same reserved word in the same cycle, the lower index succeeds and the higher index fails. With two requesters each running a five-fold atomic-increment retry loop from 0, the word ends at 10.
- R9: The response arrives exactly one cycle after the grant, on `rsp_valid` of the granted requester only. While `rsp_valid` of a lane is low, its `rsp_data` is zero.
- R10: After reset all words are zero, no reservation is held, and no response or grant is asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | N_REQ | Request pending, one bit per requester, held until granted |
| req_op | input | 2*N_REQ | Operation per requester: 00 load, 01 store, 10 linked load, 11 conditional store |
| req_addr | input | ADDR_W*N_REQ | Word address per requester |
| req_wdata | input | DATA_W*N_REQ | Store data per requester |
| req_gnt | output | N_REQ | Request taken this cycle |
| rsp_valid | output | N_REQ | Response for the requester granted one cycle earlier |
| rsp_data | output | DATA_W*N_REQ | Read word, store-conditional status (0/1), or 0 for stores |

## Verification
The bench targets the ways a reservation can outlive its right to succeed. These are a store by the other requester between the linked load and the conditional store, a second conditional store after the first, a linked load that moved to another address, and a conditional store to a word other than the reserved one. A design that missed any of these would return 1 and overwrite memory. The bench then races two increment loops to the same word. If the winner's write did not break the loser's reservation, both conditional stores would succeed and the final count would fall below 10. If arbitration were wrong, the response order and latency of simultaneous requests would show it.

// File: rtl/llsc_pkg.sv
package llsc_pkg;
   localparam int OP_W = 2;
   typedef enum logic [OP_W-1:0] {
      OP_LOAD  = 2'b00,
      OP_STORE = 2'b01,
      OP_LINK  = 2'b10,
      OP_COND  = 2'b11
   } llsc_op_e;
endpackage

// File: rtl/llsc_prio_arb.sv
module llsc_prio_arb #(
   parameter int N = 2
) (
   input  logic [N-1:0] req,
   output logic [N-1:0] gnt
);
   logic [N:0] seen;
   assign seen[0] = 1'b0;
   for (genvar i = 0; i < N; i++) begin : g_chain
      assign gnt[i]    = req[i] & ~seen[i];
      assign seen[i+1] = seen[i] | req[i];
   end
endmodule

// File: rtl/llsc_word_array.sv
module llsc_word_array #(
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;
   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
         rdata <= '0;
      end else begin
         rdata <= mem[addr];
         if (we) mem[addr] <= wdata;
      end
   end

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem[$past(addr)] == $past(wdata)); // R3
endmodule

// File: rtl/llsc_resv_slot.sv
module llsc_resv_slot
   import llsc_pkg::*;
#(
   parameter int ADDR_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              own_gnt,
   input  llsc_op_e          op,
   input  logic [ADDR_W-1:0] addr,
   input  logic              cmt_wr,
   output logic              match
);
   logic              hold;
   logic [ADDR_W-1:0] tag;

   assign match = hold && (tag == addr);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold <= 1'b0;
         tag  <= '0;
      end else if (own_gnt && op == OP_LINK) begin
         hold <= 1'b1;
         tag  <= addr;
      end else if (own_gnt && op == OP_COND) begin
         hold <= 1'b0;
      end else if (cmt_wr && match) begin
         hold <= 1'b0;
      end
   end

   AST_LINK_SETS: assert property (@(posedge clk) disable iff (!rst_n)
      (own_gnt && op == OP_LINK) |=> hold && tag == $past(addr)); // R2
   AST_COND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (own_gnt && op == OP_COND) |=> !hold); // R5
   AST_STORE_KILLS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmt_wr && op == OP_STORE && match) |=> !hold); // R6
   AST_LOAD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
      (own_gnt && op == OP_LOAD) |=> $stable(hold) && $stable(tag)); // R1
endmodule

// File: rtl/llsc_monitor.sv
module llsc_monitor
   import llsc_pkg::*;
#(
   parameter int N_REQ  = 2,
   parameter int ADDR_W = 4,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [N_REQ-1:0]        req_valid,
   input  logic [N_REQ*OP_W-1:0]   req_op,
   input  logic [N_REQ*ADDR_W-1:0] req_addr,
   input  logic [N_REQ*DATA_W-1:0] req_wdata,
   output logic [N_REQ-1:0]        req_gnt,
   output logic [N_REQ-1:0]        rsp_valid,
   output logic [N_REQ*DATA_W-1:0] rsp_data
);
   if (N_REQ < 1) begin : g_bad_nreq
      $error("N_REQ must be at least 1");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("ADDR_W must lie in 1..12");
   end
   if (DATA_W < 2) begin : g_bad_data
      $error("DATA_W must be at least 2");
   end

   llsc_op_e          sel_op;
   logic [ADDR_W-1:0] sel_addr;
   logic [DATA_W-1:0] sel_wdata;
   logic [N_REQ-1:0]  resv_match;
   logic              busy, cond_ok, mem_we;
   logic [DATA_W-1:0] rd_word, rsp_val;
   logic [N_REQ-1:0]  rsp_valid_q;
   logic              rsp_cond_q, rsp_ok_q, rsp_store_q;

   llsc_prio_arb #(.N(N_REQ)) u_arb (.req(req_valid), .gnt(req_gnt));

   always_comb begin
      sel_op    = OP_LOAD;
      sel_addr  = '0;
      sel_wdata = '0;
      for (int i = 0; i < N_REQ; i++) begin
         if (req_gnt[i]) begin
            sel_op    = llsc_op_e'(req_op[i*OP_W +: OP_W]);
            sel_addr  = req_addr[i*ADDR_W +: ADDR_W];
            sel_wdata = req_wdata[i*DATA_W +: DATA_W];
         end
      end
   end

   assign busy    = |req_gnt;
   assign cond_ok = |(req_gnt & resv_match);
   assign mem_we  = busy && (sel_op == OP_STORE || (sel_op == OP_COND && cond_ok));

   for (genvar i = 0; i < N_REQ; i++) begin : g_slot
      llsc_resv_slot #(.ADDR_W(ADDR_W)) u_slot (
         .clk    (clk),
         .rst_n  (rst_n),
         .own_gnt(req_gnt[i]),
         .op     (sel_op),
         .addr   (sel_addr),
         .cmt_wr (mem_we),
         .match  (resv_match[i])
      );
   end

   llsc_word_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
      .clk  (clk),
      .rst_n(rst_n),
      .we   (mem_we),
      .addr (sel_addr),
      .wdata(sel_wdata),
      .rdata(rd_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid_q <= '0;
         rsp_cond_q  <= 1'b0;
         rsp_ok_q    <= 1'b0;
         rsp_store_q <= 1'b0;
      end else begin
         rsp_valid_q <= req_gnt;
         rsp_cond_q  <= busy && sel_op == OP_COND;
         rsp_ok_q    <= cond_ok;
         rsp_store_q <= busy && sel_op == OP_STORE;
      end
   end

   assign rsp_val   = rsp_cond_q  ? {{(DATA_W-1){1'b0}}, rsp_ok_q} :
                      rsp_store_q ? '0 : rd_word;
   assign rsp_valid = rsp_valid_q;

   for (genvar i = 0; i < N_REQ; i++) begin : g_rsp
      assign rsp_data[i*DATA_W +: DATA_W] = rsp_valid_q[i] ? rsp_val : '0;
   end

   AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(req_gnt)); // R7
   AST_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid[0] |-> req_gnt[0]); // R7
   AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> rsp_valid == $past(req_gnt)); // R9
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !(|req_valid) |=> rsp_valid == '0); // R9
   AST_FAIL_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && sel_op == OP_COND && !(|(req_gnt & resv_match))) |-> !mem_we); // R4
endmodule

// File: tb/test_llsc_monitor.sv
`timescale 1ns/1ps
module test_llsc_monitor;
   localparam int N = 2, AW = 4, DW = 8;
   localparam logic [1:0] LD = 2'b00, ST = 2'b01, LL = 2'b10, SC = 2'b11;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0]  req_valid = '0;
   logic [2*N-1:0] req_op = '0;
   logic [AW*N-1:0] req_addr = '0;
   logic [DW*N-1:0] req_wdata = '0;
   logic [N-1:0]  req_gnt, rsp_valid;
   logic [DW*N-1:0] rsp_data;

   int checks = 0, errors = 0;
   logic [7:0] res0, res1;
   int lat0, lat1;

   always #2.5 clk = ~clk;

   llsc_monitor #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW)) i_llsc_monitor (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_addr(req_addr), .req_wdata(req_wdata), .req_gnt(req_gnt),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data));

   typedef struct packed {
      logic [1:0] op; logic [3:0] addr; logic [7:0] wd; logic [7:0] exp; logic [7:0] rq;
   } vec_t;
   localparam int NV = 17;
   localparam vec_t VECS [NV] = '{
      '{LD, 4'h3, 8'h00, 8'h00, 8'd10}, // R10 word is zero after reset
      '{ST, 4'h3, 8'h5A, 8'h00, 8'd6},  // R6 store acks with 0
      '{LD, 4'h3, 8'h00, 8'h5A, 8'd1},  // R1
      '{SC, 4'h3, 8'h11, 8'h00, 8'd4},  // R4 no reservation
      '{LD, 4'h3, 8'h00, 8'h5A, 8'd4},  // R4 memory unchanged
      '{LL, 4'h3, 8'h00, 8'h5A, 8'd2},  // R2
      '{SC, 4'h3, 8'h22, 8'h01, 8'd3},  // R3
      '{LD, 4'h3, 8'h00, 8'h22, 8'd3},  // R3 write landed
      '{SC, 4'h3, 8'h33, 8'h00, 8'd5},  // R5 second SC fails
      '{LD, 4'h3, 8'h00, 8'h22, 8'd5},  // R5
      '{LL, 4'h3, 8'h00, 8'h22, 8'd2},  // R2
      '{LL, 4'h7, 8'h00, 8'h00, 8'd2},  // R2 replaces reservation
      '{SC, 4'h3, 8'h44, 8'h00, 8'd2},  // R2 old address fails
      '{LD, 4'h3, 8'h00, 8'h22, 8'd2},  // R2
      '{LL, 4'h7, 8'h00, 8'h00, 8'd2},  // R2
      '{SC, 4'h2, 8'h55, 8'h00, 8'd4},  // R4 other address
      '{LD, 4'h2, 8'h00, 8'h00, 8'd4}   // R4
   };

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic drive(input int r, input logic [1:0] o, input logic [3:0] a, input logic [7:0] d);
      req_valid[r] = 1'b1;
      req_op[r*2 +: 2] = o;
      req_addr[r*AW +: AW] = a;
      req_wdata[r*DW +: DW] = d;
   endtask

   task automatic run_pair(input bit e0, input logic [1:0] o0, input logic [3:0] a0, input logic [7:0] d0,
                           input bit e1, input logic [1:0] o1, input logic [3:0] a1, input logic [7:0] d1);
      bit p0, p1;
      int cnt;
      @(negedge clk);
      if (e0) drive(0, o0, a0, d0);
      if (e1) drive(1, o1, a1, d1);
      p0 = e0; p1 = e1; lat0 = 0; lat1 = 0; cnt = 0;
      while ((p0 || p1) && cnt < 20) begin
         @(negedge clk);
         cnt++;
         if (p0) begin
            lat0++;
            if (rsp_valid[0]) begin res0 = rsp_data[7:0]; p0 = 0; req_valid[0] = 1'b0; end
         end
         if (p1) begin
            lat1++;
            if (rsp_valid[1]) begin res1 = rsp_data[15:8]; p1 = 0; req_valid[1] = 1'b0; end
         end
      end
      if (p0 || p1) chk("R9 response missing", 8'd1, 8'd0);
   endtask

   task automatic finish_run;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      #1000000;
      errors++;
      $display("FAIL watchdog actual=running expected=done");
      finish_run();
   end

   initial begin
      logic [7:0] v0, v1, s0, s1;
      int done0, done1, rounds;
      bit first;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R10 rsp_valid after reset", {6'b0, rsp_valid}, 8'h00);
      chk("R10 gnt idle after reset", {6'b0, req_gnt}, 8'h00);

      for (int k = 0; k < NV; k++) begin
         run_pair(1'b1, VECS[k].op, VECS[k].addr, VECS[k].wd, 1'b0, LD, 4'h0, 8'h0);
         chk($sformatf("R%0d vector %0d data", VECS[k].rq, k), res0, VECS[k].exp);
         chk($sformatf("R9 vector %0d latency", k), 8'(lat0), 8'd1);
      end

      // R6: store from requester 1 kills requester 0 reservation
      run_pair(1, LL, 4'h9, 0, 0, LD, 0, 0);
      run_pair(0, LD, 0, 0, 1, ST, 4'h9, 8'h01);
      run_pair(1, SC, 4'h9, 8'h77, 0, LD, 0, 0);
      chk("R6 SC after foreign store", res0, 8'h00);
      run_pair(1, LD, 4'h9, 0, 0, LD, 0, 0);
      chk("R6 word keeps store value", res0, 8'h01);
      // R6: store to another word leaves reservation
      run_pair(1, LL, 4'h9, 0, 0, LD, 0, 0);
      run_pair(0, LD, 0, 0, 1, ST, 4'h8, 8'h02);
      run_pair(1, SC, 4'h9, 8'h66, 0, LD, 0, 0);
      chk("R6 SC survives unrelated store", res0, 8'h01);

      // R7: simultaneous loads served lowest index first
      run_pair(1, LD, 4'h3, 0, 1, LD, 4'h3, 0);
      chk("R7 low index latency", 8'(lat0), 8'd1);
      chk("R7 high index waits", 8'(lat1), 8'd2);
      chk("R7 high index data", res1, 8'h22);

      // R8: contested increment loops
      done0 = 0; done1 = 0; rounds = 0; first = 1;
      while ((done0 < 5 || done1 < 5) && rounds < 30) begin
         bit a0, a1;
         a0 = done0 < 5; a1 = done1 < 5;
         run_pair(a0, LL, 4'hC, 0, a1, LL, 4'hC, 0);
         v0 = res0; v1 = res1;
         run_pair(a0, SC, 4'hC, v0 + 8'd1, a1, SC, 4'hC, v1 + 8'd1);
         s0 = a0 ? res0 : 8'h0; s1 = a1 ? res1 : 8'h0;
         if (a0 && a1) begin
            chk("R8 at most one winner per round", 8'((s0 + s1) > 1), 8'd0);
            if (first) begin
               chk("R8 low index wins", s0, 8'h01);
               chk("R8 high index fails", s1, 8'h00);
               first = 0;
            end
         end
         done0 += int'(s0); done1 += int'(s1);
         rounds++;
      end
      run_pair(1, LD, 4'hC, 0, 0, LD, 0, 0);
      chk("R8 final count", res0, 8'd10);

      @(negedge clk);
      chk("R9 idle no response", {6'b0, rsp_valid}, 8'h00);
      finish_run();
   end
endmodule